// File: doc/BRIEF.md
# Parallel DAC bus write sequencer

This block sits on the host side of a dual-channel 12-bit converter that has a parallel bus. It takes commands over a valid/ready handshake and turns each one into a timed sequence on the converter pins: an active-low chip select, a channel select, a data word, two active-low load strobes (one per channel) and an active-low converter reset. Every pin comes straight from a flop, so none of them glitches.

Every timing minimum is given in nanoseconds next to the clock period. Each one is converted to a whole number of cycles, rounded up and never below one. A single down-counter then holds each bus phase for its cycle count. A write can load its channel at once, or leave the load for later. After two deferred writes, one for each channel, a load-both command pulses both strobes on the same edge, so both outputs change together.

Top module: `dac_bus_seq`

## Requirements
- R1: After block reset `dac_cs_n`=1, `dac_ld_n`=2'b11, `dac_rst_n`=1, `dac_sel`=0, `dac_data`=0 and `cmd_ready`=1.
- R2: `cmd_ready` is high only while the bus is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` goes low at that edge unless the op code is 3, and stays low until the last hold interval of the bus cycle has ended.
- R3: A write (op code 0) drives `dac_data` and `dac_sel` (0 = channel A, 1 = channel B) to the command's values on the accepting edge. At that same edge it pulls `dac_cs_n` low. `dac_cs_n` stays low for exactly max(chip-select width, select setup, data setup) cycles, and data and select do not change while it is low.
- R4: Data and select stay unchanged for at least the data-hold cycle count after `dac_cs_n` rises.
- R5: A write with `cmd_defer`=0 lowers the addressed strobe (bit 0 for channel A, bit 1 for channel B) max(data hold, load setup) cycles after `dac_cs_n` rises. The strobe stays low for the load-width cycle count, and the other strobe stays high.
- R6: After a load strobe rises, `cmd_ready` stays low, and data and select stay unchanged, for the load-hold cycle count.
- R7: A write with `cmd_defer`=1 lowers no load strobe. `cmd_ready` returns after the chip-select phase plus the data-hold cycles.
- R8: Load-both (op code 1) leaves `dac_cs_n` high. Both strobes fall on the same edge after the load-setup cycle count, and both rise together after the load-width cycle count.
- R9: Reset pulse (op code 2) holds `dac_rst_n` low for the reset-width cycle count. Chip select and both strobes stay high during the pulse.
- R10: Op code 3 is accepted and has no effect: `cmd_ready` stays high and no pin changes.
- R11: Each interval in cycles is ceil(minimum_ns / CLK_NS), and never less than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | 0 write, 1 load both, 2 reset pulse, 3 no operation |
| cmd_chan | input | 1 | Write channel: 0 = A, 1 = B |
| cmd_defer | input | 1 | Write without loading the channel |
| cmd_data | input | DATA_W | Write data word |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_sel | output | 1 | Converter channel select |
| dac_data | output | DATA_W | Converter data bus |
| dac_ld_n | output | 2 | Load strobes, bit 0 channel A, bit 1 channel B, active low |
| dac_rst_n | output | 1 | Converter reset, active low |

## Verification
The hardest case to reach from the ports is a command that arrives on the first idle edge after the previous hold interval. In that case the data and select lines change as close to the previous chip-select or strobe rising edge as the design allows. The stimulus keeps `cmd_valid` high across consecutive commands, so each one is taken at the earliest edge the handshake permits. The bench timestamps every pin edge at that point to confirm the hold times are still met. A second sequence runs deferred writes to both channels and then a load-both command, to show that the two strobes fall together.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    OP_WRITE     = 2'd0,
    OP_LOAD_BOTH = 2'd1,
    OP_PULSE_RST = 2'd2,
    OP_NOP       = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEL  = 3'd1,
    ST_GAP  = 3'd2,
    ST_LD   = 3'd3,
    ST_LH   = 3'd4,
    ST_RST  = 3'd5
  } st_e;

  // Whole cycles covering a nanosecond minimum, rounded up, never zero.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned clk_ns);
    int unsigned c;
    if (clk_ns == 0) return 1;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= len - CNT_W'(1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire = (cnt_q == '0);

endmodule

// File: rtl/dac_seq_fsm.sv
module dac_seq_fsm
  import dac_seq_pkg::*;
#(
  parameter int unsigned L_CS   = 3,
  parameter int unsigned L_DH   = 1,
  parameter int unsigned L_LS   = 2,
  parameter int unsigned L_LDW  = 2,
  parameter int unsigned L_LH   = 1,
  parameter int unsigned L_RSW  = 3,
  parameter int unsigned CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_chan,
  input  logic             cmd_defer,
  input  logic             tmr_expire,
  output st_e              st_nx,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  output logic             accept,
  output logic             wr_take,
  output logic [1:0]       ld_mask,
  output logic             cmd_ready
);

  localparam int unsigned L_GAPLD = max2(L_DH, L_LS);

  st_e        st_q;
  logic [1:0] mask_q, mask_d;
  op_e        op;

  assign op        = op_e'(cmd_op);
  assign cmd_ready = (st_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign wr_take   = accept && (op == OP_WRITE);
  assign ld_mask   = mask_q;

  always_comb begin
    st_nx  = st_q;
    mask_d = mask_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_WRITE: begin
              st_nx  = ST_SEL;
              mask_d = cmd_defer ? 2'b00 : (cmd_chan ? 2'b10 : 2'b01);
            end
            OP_LOAD_BOTH: begin
              st_nx  = ST_GAP;
              mask_d = 2'b11;
            end
            OP_PULSE_RST: begin
              st_nx  = ST_RST;
              mask_d = 2'b00;
            end
            default: st_nx = ST_IDLE;
          endcase
        end
      end
      ST_SEL:  if (tmr_expire) st_nx = ST_GAP;
      ST_GAP:  if (tmr_expire) st_nx = (mask_q != 2'b00) ? ST_LD : ST_IDLE;
      ST_LD:   if (tmr_expire) st_nx = ST_LH;
      ST_LH:   if (tmr_expire) st_nx = ST_IDLE;
      ST_RST:  if (tmr_expire) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign tmr_load = (st_nx != st_q);

  always_comb begin
    unique case (st_nx)
      ST_SEL:  tmr_len = CNT_W'(L_CS);
      ST_GAP: begin
        if (st_q == ST_IDLE)       tmr_len = CNT_W'(L_LS);
        else if (mask_q != 2'b00)  tmr_len = CNT_W'(L_GAPLD);
        else                       tmr_len = CNT_W'(L_DH);
      end
      ST_LD:   tmr_len = CNT_W'(L_LDW);
      ST_LH:   tmr_len = CNT_W'(L_LH);
      ST_RST:  tmr_len = CNT_W'(L_RSW);
      default: tmr_len = CNT_W'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mask_q <= 2'b00;
    end else begin
      st_q   <= st_nx;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/dac_seq_pins.sv
module dac_seq_pins
  import dac_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  st_e               st_nx,
  input  logic              wr_take,
  input  logic              cmd_chan,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [1:0]        ld_mask,
  output logic              dac_cs_n,
  output logic              dac_sel,
  output logic [DATA_W-1:0] dac_data,
  output logic [1:0]        dac_ld_n,
  output logic              dac_rst_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_cs_n  <= 1'b1;
      dac_sel   <= 1'b0;
      dac_data  <= '0;
      dac_ld_n  <= 2'b11;
      dac_rst_n <= 1'b1;
    end else begin
      dac_cs_n  <= (st_nx != ST_SEL);
      dac_rst_n <= (st_nx != ST_RST);
      dac_ld_n  <= (st_nx == ST_LD) ? ~ld_mask : 2'b11;
      if (wr_take) begin
        dac_sel  <= cmd_chan;
        dac_data <= cmd_data;
      end
    end
  end

endmodule

// File: rtl/dac_bus_seq.sv
module dac_bus_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned DATA_W        = 12,
  parameter int unsigned CLK_NS        = 10,
  parameter int unsigned CS_LOW_NS     = 30,
  parameter int unsigned SEL_SETUP_NS  = 30,
  parameter int unsigned DATA_SETUP_NS = 30,
  parameter int unsigned DATA_HOLD_NS  = 10,
  parameter int unsigned LD_SETUP_NS   = 20,
  parameter int unsigned LD_HOLD_NS    = 10,
  parameter int unsigned LD_LOW_NS     = 20,
  parameter int unsigned RST_LOW_NS    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_chan,
  input  logic              cmd_defer,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              dac_cs_n,
  output logic              dac_sel,
  output logic [DATA_W-1:0] dac_data,
  output logic [1:0]        dac_ld_n,
  output logic              dac_rst_n
);

  // Interval lengths in cycles (R11)
  localparam int unsigned L_CS  = max2(ns_to_cycles(CS_LOW_NS, CLK_NS),
                                       max2(ns_to_cycles(SEL_SETUP_NS, CLK_NS),
                                            ns_to_cycles(DATA_SETUP_NS, CLK_NS)));
  localparam int unsigned L_DH  = ns_to_cycles(DATA_HOLD_NS, CLK_NS);
  localparam int unsigned L_LS  = ns_to_cycles(LD_SETUP_NS, CLK_NS);
  localparam int unsigned L_LDW = ns_to_cycles(LD_LOW_NS, CLK_NS);
  localparam int unsigned L_LH  = ns_to_cycles(LD_HOLD_NS, CLK_NS);
  localparam int unsigned L_RSW = ns_to_cycles(RST_LOW_NS, CLK_NS);
  localparam int unsigned L_MAX = max2(max2(L_CS, max2(L_DH, L_LS)),
                                       max2(max2(L_LDW, L_LH), L_RSW));
  localparam int unsigned CNT_W = $clog2(L_MAX + 1);

  // Internal events, named for the checker
  st_e              st_nx;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_len;
  logic             tmr_expire;
  logic             accept;
  logic             wr_take;
  logic [1:0]       ld_mask;

  dac_seq_fsm #(
    .L_CS (L_CS), .L_DH (L_DH), .L_LS (L_LS),
    .L_LDW(L_LDW), .L_LH(L_LH), .L_RSW(L_RSW), .CNT_W(CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_chan  (cmd_chan),
    .cmd_defer (cmd_defer),
    .tmr_expire(tmr_expire),
    .st_nx     (st_nx),
    .tmr_load  (tmr_load),
    .tmr_len   (tmr_len),
    .accept    (accept),
    .wr_take   (wr_take),
    .ld_mask   (ld_mask),
    .cmd_ready (cmd_ready)
  );

  dac_seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .len   (tmr_len),
    .expire(tmr_expire)
  );

  dac_seq_pins #(.DATA_W(DATA_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_nx    (st_nx),
    .wr_take  (wr_take),
    .cmd_chan (cmd_chan),
    .cmd_data (cmd_data),
    .ld_mask  (ld_mask),
    .dac_cs_n (dac_cs_n),
    .dac_sel  (dac_sel),
    .dac_data (dac_data),
    .dac_ld_n (dac_ld_n),
    .dac_rst_n(dac_rst_n)
  );

endmodule

// File: rtl/dac_seq_chk.sv
module dac_seq_chk #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned L_CS   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_op,
  input logic              cmd_ready,
  input logic              accept,
  input logic              dac_cs_n,
  input logic              dac_sel,
  input logic [DATA_W-1:0] dac_data,
  input logic [1:0]        dac_ld_n,
  input logic              dac_rst_n
);

  logic [15:0] cs_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cs_low_cnt <= '0;
    else if (!dac_cs_n) cs_low_cnt <= cs_low_cnt + 16'd1;
    else               cs_low_cnt <= '0;
  end

  a_r2_idle_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (dac_cs_n && dac_ld_n == 2'b11 && dac_rst_n));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op != 2'd3) |=> !cmd_ready);

  a_r3_cs_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |-> (cs_low_cnt == 16'(L_CS)));

  a_r3_stable_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!dac_cs_n && !$past(dac_cs_n)) |-> ($stable(dac_data) && $stable(dac_sel)));

  a_r4_hold_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_cs_n) |=> ($stable(dac_data) && $stable(dac_sel)));

  a_r5_no_load_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_cs_n |-> (dac_ld_n == 2'b11));

  a_r6_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dac_ld_n[0]) || $rose(dac_ld_n[1])) |-> !cmd_ready);

  a_r9_reset_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_rst_n |-> (dac_cs_n && dac_ld_n == 2'b11));

  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 2'd3) |=> (cmd_ready && $stable(dac_data) && $stable(dac_sel)));

endmodule

bind dac_bus_seq dac_seq_chk #(.DATA_W(DATA_W), .L_CS(L_CS)) u_chk (.*);

// File: tb/test_dac_bus_seq.sv
module test_dac_bus_seq;

  localparam int CLK_PERIOD = 10;
  localparam int NS_CS = 30, NS_AS = 30, NS_DS = 30, NS_DH = 10;
  localparam int NS_LS = 20, NS_LH = 10, NS_LDW = 20, NS_RSW = 30;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_CS  = mx(cyc(NS_CS), mx(cyc(NS_AS), cyc(NS_DS)));
  localparam int C_DH  = cyc(NS_DH);
  localparam int C_LS  = cyc(NS_LS);
  localparam int C_LDW = cyc(NS_LDW);
  localparam int C_LH  = cyc(NS_LH);
  localparam int C_RSW = cyc(NS_RSW);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic        cmd_chan;
  logic        cmd_defer;
  logic [11:0] cmd_data;
  logic        dac_cs_n, dac_sel, dac_rst_n;
  logic [11:0] dac_data;
  logic [1:0]  dac_ld_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_bus_seq #(
    .DATA_W(12), .CLK_NS(CLK_PERIOD),
    .CS_LOW_NS(NS_CS), .SEL_SETUP_NS(NS_AS), .DATA_SETUP_NS(NS_DS),
    .DATA_HOLD_NS(NS_DH), .LD_SETUP_NS(NS_LS), .LD_HOLD_NS(NS_LH),
    .LD_LOW_NS(NS_LDW), .RST_LOW_NS(NS_RSW)
  ) i_dac_bus_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_defer(cmd_defer), .cmd_data(cmd_data),
    .dac_cs_n(dac_cs_n), .dac_sel(dac_sel), .dac_data(dac_data),
    .dac_ld_n(dac_ld_n), .dac_rst_n(dac_rst_n)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    n_cyc = 0;
  bit    started = 0;
  bit    done = 0;
  string cur_req = "R1";

  // ---------------- reference model ----------------
  typedef struct packed {
    logic       cs_n;
    logic [1:0] ld_n;
    logic       rst_n;
    logic       rdy;
  } vec_t;

  vec_t        q[$];
  vec_t        cur;
  bit          m_ready;
  bit          m_acc;
  logic        m_sel;
  logic [11:0] m_data;

  function automatic vec_t mk(input logic cs, input logic [1:0] ld, input logic rs, input logic rd);
    vec_t v;
    v.cs_n = cs; v.ld_n = ld; v.rst_n = rs; v.rdy = rd;
    return v;
  endfunction

  task automatic push_n(input int n, input vec_t v);
    for (int i = 0; i < n; i++) q.push_back(v);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      cur     = mk(1'b1, 2'b11, 1'b1, 1'b1);
      m_ready = 1'b1;
      m_acc   = 1'b0;
      m_sel   = 1'b0;
      m_data  = '0;
    end else begin
      m_acc = cmd_valid && m_ready;
      if (m_acc) begin
        case (cmd_op)
          2'd0: begin
            m_sel  = cmd_chan;
            m_data = cmd_data;
            push_n(C_CS, mk(1'b0, 2'b11, 1'b1, 1'b0));
            if (cmd_defer) begin
              push_n(C_DH, mk(1'b1, 2'b11, 1'b1, 1'b0));
            end else begin
              push_n(mx(C_DH, C_LS), mk(1'b1, 2'b11, 1'b1, 1'b0));
              push_n(C_LDW, mk(1'b1, cmd_chan ? 2'b01 : 2'b10, 1'b1, 1'b0));
              push_n(C_LH, mk(1'b1, 2'b11, 1'b1, 1'b0));
            end
          end
          2'd1: begin
            push_n(C_LS, mk(1'b1, 2'b11, 1'b1, 1'b0));
            push_n(C_LDW, mk(1'b1, 2'b00, 1'b1, 1'b0));
            push_n(C_LH, mk(1'b1, 2'b11, 1'b1, 1'b0));
          end
          2'd2: push_n(C_RSW, mk(1'b1, 2'b11, 1'b0, 1'b0));
          default: ;
        endcase
      end
      if (q.size() != 0) cur = q.pop_front();
      else               cur = mk(1'b1, 2'b11, 1'b1, 1'b1);
      m_ready = cur.rdy;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_chk++;
      if (dac_cs_n !== cur.cs_n || dac_ld_n !== cur.ld_n || dac_rst_n !== cur.rst_n ||
          cmd_ready !== cur.rdy || dac_sel !== m_sel || dac_data !== m_data) begin
        n_fail++;
        $display("FAIL %s t=%0t cs_n=%b/%b ld_n=%b/%b rst_n=%b/%b ready=%b/%b sel=%b/%b data=%h/%h (actual/expected)",
                 cur_req, $time, dac_cs_n, cur.cs_n, dac_ld_n, cur.ld_n, dac_rst_n, cur.rst_n,
                 cmd_ready, cur.rdy, dac_sel, m_sel, dac_data, m_data);
      end
    end
  end

  // ---------------- pin edge timestamps ----------------
  time t_cs_fall, t_cs_rise, t_dchg, t_ld_rise, t_rst_fall;
  time t_ld_fall[2];
  bit  have_cs_rise = 0, have_ld_rise = 0;
  int  n_ld_falls = 0;
  bit  both_fell = 0;
  logic [1:0] ld_prev = 2'b11;

  task automatic chk_min(input string req, input string what, input time got, input int lim);
    n_chk++;
    if (got < time'(lim)) begin
      n_fail++;
      $display("FAIL %s %s interval=%0t expected>=%0d", req, what, got, lim);
    end
  endtask

  always @(negedge dac_cs_n) if (started) t_cs_fall = $time;

  always @(posedge dac_cs_n) begin
    if (started) begin
      chk_min("R3", "cs low width", $time - t_cs_fall, NS_CS);
      chk_min("R11", "cs low exact cycles", $time - t_cs_fall, C_CS * CLK_PERIOD);
      chk_min("R3", "sel/data setup", $time - t_dchg, mx(NS_AS, NS_DS));
      t_cs_rise = $time;
      have_cs_rise = 1;
    end
  end

  always @(dac_data or dac_sel) begin
    if (started) begin
      if (have_cs_rise) chk_min("R4", "data hold after cs", $time - t_cs_rise, NS_DH);
      if (have_ld_rise) chk_min("R6", "data hold after load", $time - t_ld_rise, NS_LH);
      t_dchg = $time;
    end
  end

  always @(dac_ld_n) begin
    if (started) begin
      if (dac_ld_n == 2'b00 && ld_prev == 2'b11) both_fell = 1;
      for (int b = 0; b < 2; b++) begin
        if (ld_prev[b] && !dac_ld_n[b]) begin
          n_ld_falls++;
          t_ld_fall[b] = $time;
          if (have_cs_rise) chk_min("R5", "load setup", $time - t_cs_rise, NS_LS);
        end
        if (!ld_prev[b] && dac_ld_n[b]) begin
          chk_min("R5", "load low width", $time - t_ld_fall[b], NS_LDW);
          t_ld_rise = $time;
          have_ld_rise = 1;
        end
      end
    end
    ld_prev = dac_ld_n;
  end

  always @(negedge dac_rst_n) if (started) t_rst_fall = $time;
  always @(posedge dac_rst_n) if (started) chk_min("R9", "reset low width", $time - t_rst_fall, NS_RSW);

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 20000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d cycles expected<=20000", n_cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input string req, input logic [1:0] op, input logic ch,
                      input logic df, input logic [11:0] d);
    @(negedge clk);
    cur_req   = req;
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_chan  = ch;
    cmd_defer = df;
    cmd_data  = d;
    do begin
      @(posedge clk);
      #1;
    end while (!m_acc);
  endtask

  task automatic settle(input int n);
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  int falls_before;

  initial begin
    rst_n = 1'b0;
    cmd_valid = 1'b0; cmd_op = 2'd0; cmd_chan = 1'b0; cmd_defer = 1'b0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    // R1: reset state
    expect_bit("R1", "cs_n", dac_cs_n, 1'b1);
    expect_bit("R1", "ld_n both high", &dac_ld_n, 1'b1);
    expect_bit("R1", "rst_n", dac_rst_n, 1'b1);
    expect_bit("R1", "ready", cmd_ready, 1'b1);
    expect_bit("R1", "data zero", |dac_data, 1'b0);

    // R3/R5/R6: immediate writes to each channel
    send("R5", 2'd0, 1'b0, 1'b0, 12'hABC);
    settle(12);
    send("R5", 2'd0, 1'b1, 1'b0, 12'h123);
    settle(12);

    // R7 then R8: deferred writes, then one common load
    falls_before = n_ld_falls;
    send("R7", 2'd0, 1'b0, 1'b1, 12'h000);
    send("R7", 2'd0, 1'b1, 1'b1, 12'hFFF);
    settle(8);
    n_chk++;
    if (n_ld_falls != falls_before) begin
      n_fail++;
      $display("FAIL R7 load strobe falls actual=%0d expected=%0d", n_ld_falls - falls_before, 0);
    end
    both_fell = 0;
    send("R8", 2'd1, 1'b0, 1'b0, 12'h000);
    settle(8);
    expect_bit("R8", "both strobes fell together", both_fell, 1'b1);

    // R2/R4/R6: back-to-back commands held valid
    send("R2", 2'd0, 1'b0, 1'b0, 12'h800);
    send("R4", 2'd0, 1'b1, 1'b1, 12'h7FF);
    send("R6", 2'd0, 1'b0, 1'b0, 12'h001);
    send("R2", 2'd1, 1'b0, 1'b0, 12'h000);
    settle(12);

    // R9: reset pulse
    send("R9", 2'd2, 1'b0, 1'b0, 12'h000);
    settle(8);

    // R10: no-op with new data and channel must leave pins untouched
    send("R10", 2'd3, 1'b1, 1'b0, 12'h555);
    settle(4);
    expect_bit("R10", "data unchanged", dac_data == 12'h001, 1'b1);
    expect_bit("R10", "sel unchanged", dac_sel, 1'b0);
    expect_bit("R10", "ready", cmd_ready, 1'b1);

    // R11: one more write after the no-op, in a clean window
    send("R11", 2'd0, 1'b1, 1'b0, 12'hFFF);
    settle(12);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule